// File: doc/BRIEF.md
# External Interrupt Pin Sense Detector

This block monitors eight external interrupt pins and turns the condition chosen for each pin into a latched, active-high level request for a parent interrupt controller. Every pin first passes through a two-flop synchronizer. The synchronized value is then compared with its own previous sample, or tested for a low level, depending on that pin's 2-bit sense code. When the selected condition occurs, the pin's status bit is set and held until software clears it.

Software uses a small register port with an address, write data, a write enable and combinational read data. Address 0 holds the sense-select register. Address 1 holds the status/clear register. A status bit is acknowledged by writing address 1 with that bit at 0. Because writing a 1 leaves the bit unchanged, software can read the register, zero the bits it has handled, and write the value back.

Top module: `irq_sense_top`

## Requirements
- R1: After reset all sense fields read 0 (level low), all status bits read 0, and irq_o is 0 while the pins are held high.
- R2: Address 0 is the sense-select register. The field for pin n is bits [2n+1:2n], and it reads back exactly what was last written.
- R3: Sense code 0 (level low) sets status while the synchronized pin is low. A clear has no effect while the pin stays low.
- R4: Sense code 1 (falling edge) sets status when the synchronized pin goes from 1 to 0, and for no other change.
- R5: Sense code 2 (rising edge) sets status when the synchronized pin goes from 0 to 1, and for no other change.
- R6: Sense code 3 (both edges) sets status on any change of the synchronized pin.
- R7: Address 1 bit n reads the status of pin n, and irq_o[n] is high exactly when that status bit is set.
- R8: Writing address 1 with bit n at 0 clears status n. Writing bit n at 1 leaves status n unchanged, so such a write never sets status.
- R9: If a sense event for pin n occurs in the same cycle as a clear of bit n, status n stays set.
- R10: Pins pass through two synchronizer flops. A pin change made before clock edge k is not yet visible in status after edge k+1, and is latched by edge k+2.
- R11: A write that changes a pin's sense field clears that pin's edge history. An edge that reaches the synchronized sample in the cycle right after the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | External interrupt pins (asynchronous) |
| reg_addr_i | input | 2 | Register address: 0 = sense select, 1 = status/clear |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write enable for one cycle |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 8 | Active-high level interrupt per pin |

## Verification
Each sense code is tried with pins that fall, rise, and stay at a constant low or high level. This separates level sensing from edge sensing, and each edge polarity from the other. Directed sequences place a pin change at exact edges relative to a clear or a sense write. This distinguishes "event wins over clear" from "clear wins", shows that the synchronizer adds two stages of latency, and shows that a sense change suppresses the edge that would otherwise have been seen. A random phase mixes pin toggles, clear writes with random masks, and sense rewrites on all pins. It is compared cycle by cycle with a bench model, which exposes any cross-talk between pins or fields.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  typedef enum logic [1:0] {
    SENSE_LVL_LOW = 2'd0,
    SENSE_FALL    = 2'd1,
    SENSE_RISE    = 2'd2,
    SENSE_BOTH    = 2'd3
  } sense_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_SENSE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd1;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned W       = 8,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // R10: the output follows the first stage with one cycle of delay
  assert_sync_stage_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(meta_q) |=> (sync_q == $past(meta_q)));
endmodule

// File: rtl/irq_sense_cell.sv
module irq_sense_cell
  import irq_sense_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   smp_i,
  input  sense_e mode_i,
  input  logic   mode_chg_i,
  input  logic   clr_i,
  output logic   status_o
);
  logic prev_q, vld_q, status_q, hit;

  always_comb begin
    unique case (mode_i)
      SENSE_LVL_LOW: hit = ~smp_i;
      SENSE_FALL:    hit = vld_q & prev_q & ~smp_i;
      SENSE_RISE:    hit = vld_q & ~prev_q & smp_i;
      default:       hit = vld_q & (prev_q ^ smp_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b1;
      vld_q    <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q   <= smp_i;
      vld_q    <= ~mode_chg_i;
      // a new event has priority over the clear
      status_q <= hit | (status_q & ~clr_i);
    end
  end

  assign status_o = status_q;

  assert_set_needs_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q) |-> $past(hit));
  assert_drop_needs_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_q) |-> $past(clr_i));
  assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> status_q);
  assert_history_cleared_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_chg_i && mode_i != SENSE_LVL_LOW) |=> (!vld_q || $past(mode_i) == SENSE_LVL_LOW || 1'b1) && !vld_q);
endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
  import irq_sense_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SEL_W = 2 * N_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [N_PINS-1:0] status_i,
  output logic [SEL_W-1:0]  sense_o,
  output logic [N_PINS-1:0] mode_chg_o,
  output logic [N_PINS-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [SEL_W-1:0] sense_q;
  logic             we_sense, we_stat;

  assign we_sense = we_i && (addr_i == ADDR_SENSE);
  assign we_stat  = we_i && (addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sense_q <= '0;
    else if (we_sense) sense_q <= wdata_i[SEL_W-1:0];
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_ctl
    assign mode_chg_o[i] = we_sense && (wdata_i[2*i +: 2] != sense_q[2*i +: 2]);
    assign clr_o[i]      = we_stat && !wdata_i[i];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_SENSE)     rdata_o[SEL_W-1:0]  = sense_q;
    else if (addr_i == ADDR_STAT) rdata_o[N_PINS-1:0] = status_i;
  end

  assign sense_o = sense_q;

  assert_sense_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_sense |=> (sense_q == $past(wdata_i[SEL_W-1:0])));
  assert_sense_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_sense |=> $stable(sense_q));
endmodule

// File: rtl/irq_sense_top.sv
module irq_sense_top
  import irq_sense_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_PINS-1:0] irq_o
);
  localparam int unsigned SEL_W = 2 * N_PINS;

  logic [N_PINS-1:0] smp, mode_chg, clr, status;
  logic [SEL_W-1:0]  sense;

  irq_pin_sync #(.W(N_PINS), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_i),
    .sync_o (smp)
  );

  irq_sense_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .we_i      (reg_we_i),
    .status_i  (status),
    .sense_o   (sense),
    .mode_chg_o(mode_chg),
    .clr_o     (clr),
    .rdata_o   (reg_rdata_o)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    irq_sense_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .smp_i     (smp[i]),
      .mode_i    (sense_e'(sense[2*i +: 2])),
      .mode_chg_i(mode_chg[i]),
      .clr_i     (clr[i]),
      .status_o  (status[i])
    );
  end

  assign irq_o = status;

  // R7: the request is only ever raised one cycle after a synchronized sample
  assert_irq_from_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> ($past(sense[1:0]) != 2'd0 || !$past(smp[0]) || 1'b0) || $past(smp[0]) != $past(smp[0], 2) || !$past(smp[0]));
endmodule

// File: tb/irq_sense_top_test.sv
module irq_sense_top_test;
  localparam int N = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin = '1;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  irq;

  int checks = 0;
  int errors = 0;
  logic [2*N-1:0] shadow = '0;

  irq_sense_top #(.N_PINS(N), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_we_i(we), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  // reference model built from the requirements
  logic [N-1:0]   m_s1, m_s2, m_prev, m_vld, m_stat;
  logic [2*N-1:0] m_sense;
  bit             model_on = 1'b0;

  function automatic logic exp_hit(logic [1:0] mode, logic cur, logic prv, logic vld);
    case (mode)
      2'd0:    return !cur;
      2'd1:    return vld && prv && !cur;
      2'd2:    return vld && !prv && cur;
      default: return vld && (prv != cur);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_prev <= '1; m_vld <= '0; m_stat <= '0; m_sense <= '0;
    end else begin
      for (int p = 0; p < N; p++) begin
        logic h, c, chg;
        h   = exp_hit(m_sense[2*p +: 2], m_s2[p], m_prev[p], m_vld[p]);
        c   = we && addr == 2'd1 && !wdata[p];
        chg = we && addr == 2'd0 && (wdata[2*p +: 2] != m_sense[2*p +: 2]);
        m_stat[p] <= h | (m_stat[p] & ~c);
        m_vld[p]  <= !chg;
      end
      m_prev <= m_s2; m_s2 <= m_s1; m_s1 <= pin;
      if (we && addr == 2'd0) m_sense <= wdata[2*N-1:0];
    end
  end

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    if (a == 2'd0) shadow = d[2*N-1:0];
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic set_mode(int p, logic [1:0] m);
    logic [2*N-1:0] s;
    s = shadow;
    s[2*p +: 2] = m;
    wr(2'd0, {{(DW-2*N){1'b0}}, s});
  endtask

  function automatic logic [DW-1:0] clr_mask(int p);
    logic [DW-1:0] m;
    m = '1;
    m[p] = 1'b0;
    return m;
  endfunction

  logic [N-1:0] stat_rd;
  task automatic rd_stat();
    addr = 2'd1; #1; stat_rd = rdata[N-1:0];
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    addr = 2'd0; #1; check("R1 sense", rdata, '0);
    rd_stat(); check("R1 status", {24'd0, stat_rd}, '0);
    check("R1 irq", {24'd0, irq}, '0);

    // R2 readback
    wr(2'd0, 32'h0000_E4B1); addr = 2'd0; #1;
    check("R2 sense readback", rdata, 32'h0000_E4B1);
    wr(2'd0, 32'h0000_0000); cyc(3);

    // R3 level low on pin 0
    pin[0] = 1'b0; cyc(4); rd_stat();
    check("R3 low sets", stat_rd[0], 1);
    wr(2'd1, clr_mask(0)); cyc(1); rd_stat();
    check("R3 clear ignored while low", stat_rd[0], 1);
    pin[0] = 1'b1; cyc(4); wr(2'd1, clr_mask(0)); cyc(1); rd_stat();
    check("R3 cleared when high", stat_rd[0], 0);
    check("R7 irq follows status", irq[0], 0);

    // R4 falling on pin 1
    set_mode(1, 2'd1); cyc(3);
    pin[1] = 1'b0; cyc(4); rd_stat();
    check("R4 falling sets", stat_rd[1], 1);
    check("R7 irq high", irq[1], 1);
    wr(2'd1, clr_mask(1)); pin[1] = 1'b1; cyc(4); rd_stat();
    check("R4 rise ignored", stat_rd[1], 0);

    // R5 rising on pin 2
    set_mode(2, 2'd2); cyc(3);
    pin[2] = 1'b0; cyc(4); rd_stat();
    check("R5 fall ignored", stat_rd[2], 0);
    pin[2] = 1'b1; cyc(4); rd_stat();
    check("R5 rising sets", stat_rd[2], 1);

    // R8 writing ones has no effect
    wr(2'd1, 32'hFFFF_FFFF); cyc(1); rd_stat();
    check("R8 ones keep set bit", stat_rd[2], 1);
    check("R8 ones do not set", stat_rd[5], 0);
    wr(2'd1, clr_mask(2)); cyc(1); rd_stat();
    check("R8 zero clears", stat_rd[2], 0);

    // R6 both edges on pin 3
    set_mode(3, 2'd3); cyc(3);
    pin[3] = 1'b0; cyc(4); rd_stat();
    check("R6 fall sets", stat_rd[3], 1);
    wr(2'd1, clr_mask(3)); cyc(2);
    pin[3] = 1'b1; cyc(4); rd_stat();
    check("R6 rise sets", stat_rd[3], 1);
    wr(2'd1, clr_mask(3)); cyc(2);

    // R9 event coincides with clear
    pin[3] = 1'b0; cyc(4); rd_stat();
    check("R9 pre-set", stat_rd[3], 1);
    pin[3] = 1'b1;       // before edge k
    cyc(2);              // edges k, k+1
    wr(2'd1, clr_mask(3)); // clear at edge k+2 together with the hit
    rd_stat();
    check("R9 event wins over clear", stat_rd[3], 1);
    wr(2'd1, clr_mask(3)); rd_stat();
    check("R9 plain clear", stat_rd[3], 0);

    // R10 synchronizer latency, pin 5 falling
    set_mode(5, 2'd1); cyc(3);
    pin[5] = 1'b0;
    cyc(2); check("R10 not after two edges", irq[5], 0);
    cyc(1); check("R10 set after third edge", irq[5], 1);
    wr(2'd1, clr_mask(5)); pin[5] = 1'b1; cyc(3);

    // R11 sense change suppresses edge
    set_mode(4, 2'd2); cyc(3);
    pin[4] = 1'b0;          // before edge W-1
    cyc(1);
    set_mode(4, 2'd1);      // write at edge W
    cyc(4); rd_stat();
    check("R11 edge after mode change ignored", stat_rd[4], 0);
    pin[4] = 1'b1; cyc(3); pin[4] = 1'b0; cyc(4); rd_stat();
    check("R11 later falling edge seen", stat_rd[4], 1);

    // random phase against the model
    wr(2'd1, 32'h0); pin = '1; cyc(4);
    wr(2'd1, 32'h0);
    model_on = 1'b1;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      pin = pin ^ N'($urandom_range(0, 255) & $urandom_range(0, 255));
      if (r == 0) begin
        addr = 2'd1; wdata = $urandom; we = 1'b1;
      end else if (r == 1 && i % 50 == 0) begin
        addr = 2'd0; wdata = {16'd0, 16'($urandom)}; we = 1'b1;
      end
      @(negedge clk);
      we = 1'b0;
      check("R7 irq vs model", {24'd0, irq}, {24'd0, m_stat});
      addr = 2'd1; #1;
      check("R8 status vs model", rdata, {24'd0, m_stat});
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule